// File: doc/BRIEF.md
# Privileged Model-Register Read Unit

This block carries out the privileged "read a model register" operation for a simple 64-bit processor datapath. Each cycle it may receive one decoded request: two opcode bytes, a lock-prefix flag, the 64-bit count register, the current privilege level and the execution mode. When the opcode is the model-register read, the unit registers a response one clock later. That response either writes a 64-bit model register, split into two halves, to the data-high and accumulator destinations, or reports a fault.

The unit holds four read-only 64-bit model registers at fixed, parameterised addresses. Each register has a reset value and a mask of implemented bits. The legality checks are ordered:

- The lock prefix raises an invalid-opcode fault first.
- A mode or privilege violation raises a general-protection fault second.
- An unknown address raises a general-protection fault last.

A faulting request never touches the destinations.

Top module: `modelreg_read_unit`

## Requirements
- R1: A request with `reqValid`=1, `opByte0`=0x0F and `opByte1`=0x32 produces `rspValid`=1 in the next cycle only. Any other request, or no request, gives `rspValid`=0, `destWe`=0, `faultValid`=0 and unchanged destinations.
- R2: The register address is `countReg[31:0]`. `countReg[63:32]` has no effect on the response.
- R3: A legal read to a known address gives `destWe`=1, `faultValid`=0 and `faultCode`=0. It also gives `hiDest`={32'h0, reg[63:32]} and `accDest`={32'h0, reg[31:0]}.
- R4: The mode encoding is 0 real, 1 protected, 2 virtual-8086, 3 compatibility and 4 64-bit, with 5 to 7 treated as protected. In protected, compatibility and 64-bit mode, `cpl`≠0 gives a fault with `faultCode`=2'b01 (general protection, error code 0).
- R5: In real mode the read is legal at any `cpl`.
- R6: In virtual-8086 mode the read always faults with `faultCode`=2'b01, even at `cpl`=0.
- R7: In a legal mode and privilege, an address that matches no bank register faults with `faultCode`=2'b10 (general protection, address).
- R8: The lock prefix faults with `faultCode`=2'b11 (invalid opcode), ahead of every other fault.
- R9: When a mode or privilege fault and an address fault both apply, `faultCode` is 2'b01.
- R10: A faulting response has `faultValid`=1 and `destWe`=0, and `hiDest` and `accDest` keep their previous values.
- R11: Bits that a register does not implement read as zero. With the default parameters, the values read are: 0x10 gives 0x0123456789ABCDEF, 0x1B gives 0x0000000000000900, 0x174 gives 0x0000000000000008, and 0xC0000080 gives 0xDEADBEEF00000D01.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| opByte0 | input | 8 | First opcode byte |
| opByte1 | input | 8 | Second opcode byte |
| lockPrefix | input | 1 | Lock prefix present |
| countReg | input | 64 | Count register (address in low half) |
| cpl | input | 2 | Current privilege level |
| execMode | input | 3 | Execution mode |
| rspValid | output | 1 | Response valid |
| faultValid | output | 1 | Response is a fault |
| faultCode | output | 2 | 01 GP mode/privilege, 10 GP address, 11 invalid opcode |
| hiDest | output | 64 | Data-high destination value |
| accDest | output | 64 | Accumulator destination value |
| destWe | output | 1 | Destinations written this response |

## Verification
The hardest situation to reach is several faults applying at once. A locked request from virtual-8086 or non-zero privilege to an unknown address must still report only the invalid-opcode fault and must leave the destinations holding the last good read. Directed cases set up each pairing of faults right after a successful read, so that any change to the destinations shows. The random stimulus then skews the choices: lock at about one request in eight, half of the addresses taken from the bank, a wide privilege spread across all eight mode codes, and random upper count bits.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_PROT   = 3'd1,
    MODE_V86    = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } exec_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_GP_PRIV = 2'b01,
    FLT_GP_ADDR = 2'b10,
    FLT_UD      = 2'b11
  } fault_e;

  typedef struct packed {
    logic   respond;
    logic   load;
    logic   fault;
    fault_e code;
  } strobe_t;

endpackage

// File: rtl/mrr_ctrl.sv
module mrr_ctrl
  import mrr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [7:0]    opByte0,
  input  logic [7:0]    opByte1,
  input  logic          lockPrefix,
  input  logic [1:0]    cpl,
  input  logic [2:0]    execMode,
  input  logic          anyHit,
  output strobe_t       strb
);

  localparam logic [7:0] OP_ESC  = 8'h0F;
  localparam logic [7:0] OP_READ = 8'h32;

  logic   isOp;
  logic   modeBad;
  fault_e code;

  assign isOp = reqValid && (opByte0 == OP_ESC) && (opByte1 == OP_READ);

  // Virtual-8086 always refuses; any non-real mode needs ring 0.
  assign modeBad = (execMode == MODE_V86) ||
                   ((execMode != MODE_REAL) && (cpl != 2'd0));

  always_comb begin
    if (lockPrefix)   code = FLT_UD;
    else if (modeBad) code = FLT_GP_PRIV;
    else if (!anyHit) code = FLT_GP_ADDR;
    else              code = FLT_NONE;
  end

  always_comb begin
    strb.respond = isOp;
    strb.load    = isOp && (code == FLT_NONE);
    strb.fault   = isOp && (code != FLT_NONE);
    strb.code    = isOp ? code : FLT_NONE;
  end

  // R5: real mode never yields a privilege fault
  p_real_any_cpl_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isOp && !lockPrefix && execMode == MODE_REAL) |-> (strb.code != FLT_GP_PRIV));

  // R10: load and fault never strobe together
  p_load_xor_fault_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.fault));

endmodule

// File: rtl/mrr_datapath.sv
module mrr_datapath
  import mrr_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_ADDR = {
    32'hC000_0080, 32'h0000_0174, 32'h0000_001B, 32'h0000_0010},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_RESET = {
    64'hDEAD_BEEF_0000_0D01, 64'h0000_0000_0000_0008,
    64'hFEE0_0000_0000_0900, 64'h0123_4567_89AB_CDEF},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_IMPL = {
    64'hFFFF_FFFF_0000_0FFF, 64'h0000_0000_0000_FFFF,
    64'h0000_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFFF}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  strobe_t           strb,
  output logic              anyHit,
  output logic              rspValid,
  output logic              faultValid,
  output logic [1:0]        faultCode,
  output logic [DATA_W-1:0] hiDest,
  output logic [DATA_W-1:0] accDest,
  output logic              destWe
);

  localparam int HALF_W = DATA_W / 2;

  logic [NUM_REGS-1:0]               hit;
  logic [NUM_REGS-1:0][DATA_W-1:0]   regVal;
  logic [DATA_W-1:0]                 selVal;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
    assign hit[i]    = (addr == REG_ADDR[i]);
    assign regVal[i] = REG_RESET[i] & REG_IMPL[i];
  end

  always_comb begin
    selVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) selVal = selVal | regVal[i];
    end
  end

  assign anyHit = |hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= FLT_NONE;
      destWe     <= 1'b0;
      hiDest     <= '0;
      accDest    <= '0;
    end else begin
      rspValid   <= strb.respond;
      faultValid <= strb.fault;
      faultCode  <= strb.code;
      destWe     <= strb.load;
      if (strb.load) begin
        hiDest  <= {{HALF_W{1'b0}}, selVal[DATA_W-1:HALF_W]};
        accDest <= {{HALF_W{1'b0}}, selVal[HALF_W-1:0]};
      end
    end
  end

  // R3: a write always has cleared upper halves
  p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    destWe |-> (hiDest[DATA_W-1:HALF_W] == '0 && accDest[DATA_W-1:HALF_W] == '0));

  // R10: faulting response leaves destinations as they were
  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultValid) |-> ($stable(hiDest) && $stable(accDest) && !destWe));

  // R1: fault or write flags appear only with a response
  p_flags_need_rsp_r1: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid || destWe) |-> rspValid);

endmodule

// File: rtl/modelreg_read_unit.sv
module modelreg_read_unit
  import mrr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [7:0]  opByte0,
  input  logic [7:0]  opByte1,
  input  logic        lockPrefix,
  input  logic [63:0] countReg,
  input  logic [1:0]  cpl,
  input  logic [2:0]  execMode,
  output logic        rspValid,
  output logic        faultValid,
  output logic [1:0]  faultCode,
  output logic [63:0] hiDest,
  output logic [63:0] accDest,
  output logic        destWe
);

  strobe_t strb;
  logic    anyHit;
  logic    unusedCountHi;

  // R2: upper count bits take no part in addressing
  assign unusedCountHi = ^countReg[63:32];

  mrr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .opByte0    (opByte0),
    .opByte1    (opByte1),
    .lockPrefix (lockPrefix),
    .cpl        (cpl),
    .execMode   (execMode),
    .anyHit     (anyHit),
    .strb       (strb)
  );

  mrr_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (countReg[31:0]),
    .strb       (strb),
    .anyHit     (anyHit),
    .rspValid   (rspValid),
    .faultValid (faultValid),
    .faultCode  (faultCode),
    .hiDest     (hiDest),
    .accDest    (accDest),
    .destWe     (destWe)
  );

  logic isReq;
  assign isReq = reqValid && opByte0 == 8'h0F && opByte1 == 8'h32;

  p_resp_next_r1: assert property (@(posedge clk) disable iff (!rstN)
    isReq |=> rspValid);

  p_no_resp_r1: assert property (@(posedge clk) disable iff (!rstN)
    !isReq |=> !rspValid);

  p_lock_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isReq && lockPrefix) |=> (faultValid && faultCode == 2'b11));

  p_v86_gp_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isReq && !lockPrefix && execMode == 3'd2) |=> (faultValid && faultCode == 2'b01));

endmodule

// File: tb/modelreg_read_unit_bench.sv
`timescale 1ns/1ps
module modelreg_read_unit_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [7:0]  opByte0, opByte1;
  logic        lockPrefix;
  logic [63:0] countReg;
  logic [1:0]  cpl;
  logic [2:0]  execMode;
  logic        rspValid, faultValid, destWe;
  logic [1:0]  faultCode;
  logic [63:0] hiDest, accDest;

  int checks = 0;
  int errors = 0;
  logic [63:0] expHi = '0;
  logic [63:0] expAcc = '0;
  bit done = 0;

  always #4 clk = ~clk;

  modelreg_read_unit u_modelreg_read_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opByte0(opByte0),
    .opByte1(opByte1), .lockPrefix(lockPrefix), .countReg(countReg),
    .cpl(cpl), .execMode(execMode), .rspValid(rspValid),
    .faultValid(faultValid), .faultCode(faultCode), .hiDest(hiDest),
    .accDest(accDest), .destWe(destWe)
  );

  function automatic bit known(input logic [31:0] a, output logic [63:0] v);
    case (a)
      32'h0000_0010: begin v = 64'h0123_4567_89AB_CDEF; return 1; end
      32'h0000_001B: begin v = 64'h0000_0000_0000_0900; return 1; end
      32'h0000_0174: begin v = 64'h0000_0000_0000_0008; return 1; end
      32'hC000_0080: begin v = 64'hDEAD_BEEF_0000_0D01; return 1; end
      default:       begin v = '0; return 0; end
    endcase
  endfunction

  function automatic logic [1:0] expCode(input bit lk, input logic [1:0] pl,
                                         input logic [2:0] md, input bit hit);
    if (lk) return 2'b11;
    if (md == 3'd2 || (md != 3'd0 && pl != 2'd0)) return 2'b01;
    if (!hit) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doReq(input string tag, input bit v, input logic [7:0] b0,
                       input logic [7:0] b1, input bit lk, input logic [63:0] cnt,
                       input logic [1:0] pl, input logic [2:0] md);
    logic [63:0] val;
    bit hit, isOp;
    logic [1:0] c;
    hit  = known(cnt[31:0], val);
    isOp = v && b0 == 8'h0F && b1 == 8'h32;
    c    = isOp ? expCode(lk, pl, md, hit) : 2'b00;
    reqValid = v; opByte0 = b0; opByte1 = b1; lockPrefix = lk;
    countReg = cnt; cpl = pl; execMode = md;
    @(negedge clk);
    reqValid = 1'b0;
    if (isOp && c == 2'b00) begin
      expHi  = {32'h0, val[63:32]};
      expAcc = {32'h0, val[31:0]};
    end
    check(tag, rspValid == isOp, "rspValid", 64'(rspValid), 64'(isOp));
    check(tag, faultValid == (isOp && c != 0), "faultValid", 64'(faultValid), 64'(isOp && c != 0));
    check(tag, faultCode == c, "faultCode", 64'(faultCode), 64'(c));
    check(tag, destWe == (isOp && c == 0), "destWe", 64'(destWe), 64'(isOp && c == 0));
    check(tag, hiDest == expHi, "hiDest", hiDest, expHi);
    check(tag, accDest == expAcc, "accDest", accDest, expAcc);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    rstN = 1'b0; reqValid = 0; opByte0 = 0; opByte1 = 0; lockPrefix = 0;
    countReg = 0; cpl = 0; execMode = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", rspValid == 0 && faultValid == 0 && destWe == 0 && faultCode == 0,
          "flags", {60'h0, rspValid, faultValid, destWe, |faultCode}, 64'h0);
    check("R12", hiDest == 0 && accDest == 0, "dests", hiDest | accDest, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 and R11: each bank register in protected ring 0
    doReq("R3",  1, 8'h0F, 8'h32, 0, 64'h10, 0, 3'd1);
    doReq("R11", 1, 8'h0F, 8'h32, 0, 64'h1B, 0, 3'd4);
    doReq("R11", 1, 8'h0F, 8'h32, 0, 64'h174, 0, 3'd3);
    doReq("R11", 1, 8'h0F, 8'h32, 0, 64'hC000_0080, 0, 3'd1);
    // R2: upper count bits ignored
    doReq("R2",  1, 8'h0F, 8'h32, 0, 64'hFFFF_FFFF_0000_0010, 0, 3'd4);
    doReq("R2",  1, 8'h0F, 8'h32, 0, 64'h0000_0001_0000_0011, 0, 3'd4);
    // R5 real mode at ring 3
    doReq("R5",  1, 8'h0F, 8'h32, 0, 64'h174, 3, 3'd0);
    // R4 privilege faults
    doReq("R4",  1, 8'h0F, 8'h32, 0, 64'h10, 1, 3'd1);
    doReq("R4",  1, 8'h0F, 8'h32, 0, 64'h10, 3, 3'd4);
    // R6 v86 at ring 0
    doReq("R6",  1, 8'h0F, 8'h32, 0, 64'h10, 0, 3'd2);
    // R7 unknown address, protected and real
    doReq("R7",  1, 8'h0F, 8'h32, 0, 64'h11, 0, 3'd1);
    doReq("R7",  1, 8'h0F, 8'h32, 0, 64'h1234, 2, 3'd0);
    // R8 lock over all others
    doReq("R8",  1, 8'h0F, 8'h32, 1, 64'h10, 0, 3'd1);
    doReq("R8",  1, 8'h0F, 8'h32, 1, 64'h99, 3, 3'd2);
    // R9 privilege fault beats address fault
    doReq("R9",  1, 8'h0F, 8'h32, 0, 64'h99, 2, 3'd3);
    doReq("R9",  1, 8'h0F, 8'h32, 0, 64'h99, 0, 3'd2);
    // R10 destinations hold after a good read and then a fault
    doReq("R10", 1, 8'h0F, 8'h32, 0, 64'hC000_0080, 0, 3'd0);
    doReq("R10", 1, 8'h0F, 8'h32, 0, 64'h5, 0, 3'd1);
    // R1 wrong opcode and idle
    doReq("R1",  1, 8'h0F, 8'h30, 0, 64'h10, 0, 3'd1);
    doReq("R1",  1, 8'h32, 8'h0F, 0, 64'h10, 0, 3'd1);
    doReq("R1",  0, 8'h0F, 8'h32, 0, 64'h10, 0, 3'd1);

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] cnt;
      logic [31:0] pick;
      bit lk, v, goodOp;
      string tag;
      logic [63:0] dummy;
      logic [2:0] md;
      logic [1:0] pl;
      case ($urandom_range(3))
        0: pick = 32'h10;
        1: pick = 32'h1B;
        2: pick = 32'h174;
        default: pick = 32'hC000_0080;
      endcase
      if ($urandom_range(1) == 0) pick = $urandom;
      cnt    = {32'($urandom), pick};
      lk     = ($urandom_range(7) == 0);
      v      = ($urandom_range(9) != 0);
      goodOp = ($urandom_range(9) != 0);
      md     = 3'($urandom_range(7));
      pl     = ($urandom_range(1) == 0) ? 2'd0 : 2'($urandom_range(3));
      if (!(v && goodOp)) tag = "R1";
      else if (lk) tag = "R8";
      else if (md == 3'd2) tag = "R6";
      else if (md != 0 && pl != 0) tag = "R4";
      else if (!known(pick, dummy)) tag = "R7";
      else tag = "R3";
      doReq(tag, v, 8'h0F, goodOp ? 8'h32 : 8'(($urandom_range(254) + 8'h33)), lk,
            cnt, pl, md);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule